// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a register-mapped timer that produces a steady stream of equal intervals from the system clock. A prescaler turns every sixteen clock cycles into one counting tick. An interval counter climbs from zero to a programmed limit, and on the following tick it returns to zero and records one completed interval. Each completion sets a sticky status flag and increments a 12-bit count of intervals that software has not yet acknowledged. A level interrupt reports the flag when software has enabled it.

Software uses a plain strobe bus: a write strobe, a read strobe, a byte address and 32-bit data. Read data is combinational and valid in the cycle the read strobe is high. The live counter state can be read through two windows. One of them acknowledges on read: it returns the state and clears both the flag and the pending count at the end of that cycle. The other returns the same word and changes nothing. If the enable bit is cleared, the timer does not stop at once. It finishes the interval in progress and stops when the counter wraps, so software can always rely on a final clean boundary.

Top module: `period_timer`

## Requirements
- R1: After reset, every mapped offset reads 0 and `irq` is low.
- R2: Offset 0x00 is the control word. Bits [19:0] hold the limit, bit 24 starts counting and bit 25 unmasks the interrupt. It reads back as written, and all other bits read 0.
- R3: The prescaler divides the clock by 16, and an interval lasts limit+1 ticks. With limit N written from a stopped state, the first completion is visible exactly 16*(N+1) cycles after the clock edge that accepts the write.
- R4: The counter field, bits [19:0] of offsets 0x08/0x0C, rises 0,1..N and then returns to 0. On that return, bit 0 of offset 0x04 becomes 1.
- R5: The pending count, bits [31:20] of offsets 0x08/0x0C, rises by one on each completion and wraps from 4095 to 0.
- R6: A read of offset 0x08 returns the current word, then clears the status flag and the pending count.
- R7: Reads of offset 0x0C, even when held over several cycles, change neither the flag nor the pending count.
- R8: When a completion falls in the same cycle as a read of 0x08, the completion wins: the flag stays 1 and the pending count becomes 1.
- R9: `irq` is high exactly when the status flag and bit 25 are both 1. Counting and flagging go on while bit 25 is 0.
- R10: Clearing bit 24 while counting lets the current interval run to its wrap, which still counts as a completion. After that the counter holds at 0 and no further completions occur.
- R11: Writes to offsets 0x04, 0x08, 0x0C and unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R12: Starting from a stopped state, the prescaler begins again from zero, so a restart reproduces the R3 timing exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
The timer is tried with a limit of 2 and a cycle-exact watch on `irq`. A one-cycle error in the prescaler or in the interval length shows up there, both on a first start and on a restart after a drain. A limit of 3, sampled mid-interval through the side-effect-free window, exposes the counting sequence, the masked interrupt and the gap between the two read windows. A limit of 0 makes every tick a completion, which makes two corner cases reachable: an acknowledge that lands on a completion, and the pending count wrapping after 4096 intervals. Clearing the enable bit mid-interval shows whether the timer drains to a boundary or stops at once.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_STAT,
    SEL_VAL
  } rdSel_t;

  typedef struct packed {
    logic   go;
    logic   tick;
    logic   ack;
    rdSel_t rdSel;
  } tmrStrobe_t;

endpackage

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IVL_W     = 20,
  parameter int EN_BIT    = 24,
  parameter int IE_BIT    = 25,
  parameter int PRESC_DIV = 16,
  parameter logic [ADDR_W-1:0] OFS_MODE = 'h00,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_VAL  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_IMG  = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrap,
  output tmrStrobe_t        ctl,
  output logic [IVL_W-1:0]  ivl,
  output logic              modeEn,
  output logic              modeIe
);

  localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [IVL_W-1:0] ivlQ;
  logic enQ, ieQ, drainQ;
  logic goW, tickW;
  wire  unusedWr = ^wrData;

  // control word register; writes to any other offset fall through
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivlQ <= '0;
      enQ  <= 1'b0;
      ieQ  <= 1'b0;
    end else if (wrEn && addr == OFS_MODE) begin
      ivlQ <= wrData[IVL_W-1:0];
      enQ  <= wrData[EN_BIT];
      ieQ  <= wrData[IE_BIT];
    end
  end

  // keeps the timer alive after the enable drops, until the next boundary
  always_ff @(posedge clk) begin
    if (!rstN) drainQ <= 1'b0;
    else       drainQ <= enQ | (drainQ & ~wrap);
  end

  assign goW = enQ | drainQ;

  generate
    if (PRESC_DIV > 1) begin : g_div
      logic [PRESC_W-1:0] prescQ;
      always_ff @(posedge clk) begin
        if (!rstN || !goW)                            prescQ <= '0;
        else if (prescQ == PRESC_W'(PRESC_DIV - 1))   prescQ <= '0;
        else                                          prescQ <= prescQ + PRESC_W'(1);
      end
      assign tickW = goW && (prescQ == PRESC_W'(PRESC_DIV - 1));
    end else begin : g_nodiv
      assign tickW = goW;
    end
  endgenerate

  always_comb begin
    ctl.go    = goW;
    ctl.tick  = tickW;
    ctl.ack   = rdEn && (addr == OFS_VAL);
    ctl.rdSel = SEL_NONE;
    if (rdEn) begin
      if (addr == OFS_MODE)                        ctl.rdSel = SEL_MODE;
      else if (addr == OFS_STAT)                   ctl.rdSel = SEL_STAT;
      else if (addr == OFS_VAL || addr == OFS_IMG) ctl.rdSel = SEL_VAL;
    end
  end

  assign ivl    = ivlQ;
  assign modeEn = enQ;
  assign modeIe = ieQ;

endmodule

// File: rtl/ptimer_datapath.sv
module ptimer_datapath
  import ptimer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IVL_W    = 20,
  parameter int PERIOD_W = 12,
  parameter int EN_BIT   = 24,
  parameter int IE_BIT   = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          ctl,
  input  logic [IVL_W-1:0]    ivl,
  input  logic                modeEn,
  input  logic                modeIe,
  output logic                wrap,
  output logic [IVL_W-1:0]    cnt,
  output logic [PERIOD_W-1:0] periods,
  output logic                status,
  output logic                irq,
  output logic [DATA_W-1:0]   rdData
);

  logic [IVL_W-1:0]    cntQ;
  logic [PERIOD_W-1:0] perQ;
  logic                statQ;

  assign wrap = ctl.tick && (cntQ >= ivl);

  always_ff @(posedge clk) begin
    if (!rstN)         cntQ <= '0;
    else if (ctl.tick) cntQ <= wrap ? '0 : cntQ + IVL_W'(1);
  end

  // a completion outranks a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= 1'b0;
      perQ  <= '0;
    end else if (wrap) begin
      statQ <= 1'b1;
      perQ  <= ctl.ack ? PERIOD_W'(1) : perQ + PERIOD_W'(1);
    end else if (ctl.ack) begin
      statQ <= 1'b0;
      perQ  <= '0;
    end
  end

  always_comb begin
    rdData = '0;
    case (ctl.rdSel)
      SEL_MODE: begin
        rdData[IVL_W-1:0] = ivl;
        rdData[EN_BIT]    = modeEn;
        rdData[IE_BIT]    = modeIe;
      end
      SEL_STAT: rdData[0] = statQ;
      SEL_VAL: begin
        rdData[IVL_W-1:0]        = cntQ;
        rdData[IVL_W +: PERIOD_W] = perQ;
      end
      default: rdData = '0;
    endcase
  end

  assign irq     = statQ & modeIe;
  assign cnt     = cntQ;
  assign periods = perQ;
  assign status  = statQ;

endmodule

// File: rtl/period_timer.sv
module period_timer
  import ptimer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IVL_W     = 20,
  parameter int PERIOD_W  = 12,
  parameter int PRESC_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int EN_BIT = 24;
  localparam int IE_BIT = 25;

  tmrStrobe_t          ctl;
  logic [IVL_W-1:0]    ivl;
  logic                modeEn, modeIe, wrap, status;
  logic [IVL_W-1:0]    cnt;
  logic [PERIOD_W-1:0] periods;

  ptimer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IVL_W(IVL_W),
    .EN_BIT(EN_BIT), .IE_BIT(IE_BIT), .PRESC_DIV(PRESC_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .wrap(wrap), .ctl(ctl), .ivl(ivl),
    .modeEn(modeEn), .modeIe(modeIe)
  );

  ptimer_datapath #(
    .DATA_W(DATA_W), .IVL_W(IVL_W), .PERIOD_W(PERIOD_W),
    .EN_BIT(EN_BIT), .IE_BIT(IE_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ivl(ivl), .modeEn(modeEn),
    .modeIe(modeIe), .wrap(wrap), .cnt(cnt), .periods(periods),
    .status(status), .irq(irq), .rdData(rdData)
  );

endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
  parameter int IVL_W     = 20,
  parameter int PERIOD_W  = 12,
  parameter int PRESC_DIV = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                irq,
  input logic                ie,
  input logic                go,
  input logic                tick,
  input logic                ack,
  input logic                wrap,
  input logic                status,
  input logic [IVL_W-1:0]    cnt,
  input logic [PERIOD_W-1:0] periods
);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ie |-> !irq);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> status);

  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (status && cnt == '0));

  a_r5_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!ack && !wrap) |=> $stable(periods));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !wrap) |=> (!status && periods == '0));

  a_r8_wrap_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ack && wrap) |=> (status && periods == PERIOD_W'(1)));

  a_r10_idle_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    !go |-> (cnt == '0 && !tick));

  generate
    if (PRESC_DIV > 1) begin : g_gap
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

bind period_timer ptimer_checker #(
  .IVL_W(IVL_W), .PERIOD_W(PERIOD_W), .PRESC_DIV(PRESC_DIV)
) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .ie(modeIe), .go(ctl.go),
  .tick(ctl.tick), .ack(ctl.ack), .wrap(wrap), .status(status),
  .cnt(cnt), .periods(periods)
);

// File: tb/sim_period_timer.sv
`timescale 1ns/1ps
module sim_period_timer;

  localparam logic [31:0] EN = 32'h0100_0000;
  localparam logic [31:0] IE = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  period_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] valWord(int per, int c);
    return (32'(per) << 20) | 32'(c);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read with no clock edge in between: called at a falling edge
  task automatic peek(logic [7:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    rdEn = 1'b0; addr = 8'h00;
  endtask

  // one write, accepted by the next rising edge; returns at the falling edge after it
  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 8'h00; wrData = 32'h0;
  endtask

  task automatic doAck(output logic [31:0] v);
    rdEn = 1'b1; addr = 8'h08;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0; addr = 8'h00;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopAndClear();
    logic [31:0] v;
    doWrite(8'h00, 32'h0);
    waitN(120);
    doAck(v);
  endtask

  task automatic testReset();
    logic [31:0] v;
    peek(8'h00, v); check("R1 mode", v, 0);
    peek(8'h04, v); check("R1 status", v, 0);
    peek(8'h08, v); check("R1 value", v, 0);
    peek(8'h0C, v); check("R1 image", v, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic testModeReg();
    logic [31:0] v;
    doWrite(8'h00, 32'hFC0A_BCDE);
    peek(8'h00, v); check("R2 spare bits masked", v, 32'h000A_BCDE);
    doWrite(8'h00, 32'h0200_0005);
    peek(8'h00, v); check("R2 irq enable bit", v, 32'h0200_0005);
    check("R2 irq low with clear flag", 32'(irq), 0);
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    doWrite(8'h04, 32'hFFFF_FFFF);
    doWrite(8'h08, 32'hFFFF_FFFF);
    doWrite(8'h0C, 32'hFFFF_FFFF);
    doWrite(8'h10, 32'hFFFF_FFFF);
    peek(8'h00, v); check("R11 mode untouched", v, 32'h0200_0005);
    peek(8'h04, v); check("R11 status untouched", v, 0);
    peek(8'h0C, v); check("R11 value untouched", v, 0);
    peek(8'h10, v); check("R11 unmapped 0x10", v, 0);
    peek(8'h01, v); check("R11 unmapped 0x01", v, 0);
    doWrite(8'h00, 32'h0);
  endtask

  task automatic timedStart(string req);
    doWrite(8'h00, EN | IE | 32'd2);
    waitN(47);
    check({req, " irq not yet"}, 32'(irq), 0);
    waitN(1);
    check({req, " irq on time"}, 32'(irq), 1);
  endtask

  task automatic testTiming();
    logic [31:0] v;
    timedStart("R3");
    peek(8'h00, v); check("R2 enable readback", v, EN | IE | 32'd2);
    doWrite(8'h00, IE | 32'd2);
    waitN(100);
    doAck(v);
    peek(8'h04, v); check("R10 no flag after drain", v, 0);
    peek(8'h0C, v); check("R10 stopped at zero", v, 0);
    timedStart("R12");
    stopAndClear();
  endtask

  task automatic testSequence();
    logic [31:0] v;
    doWrite(8'h00, EN | 32'd3);
    waitN(20); peek(8'h0C, v); check("R4 count 1", v, valWord(0, 1));
    waitN(20); peek(8'h0C, v); check("R4 count 2", v, valWord(0, 2));
    waitN(12); peek(8'h0C, v); check("R4 count 3", v, valWord(0, 3));
    peek(8'h04, v); check("R4 flag before wrap", v, 0);
    waitN(16); peek(8'h0C, v); check("R4 wrap to 0", v, valWord(1, 0));
    peek(8'h04, v); check("R4 flag set", v, 1);
    check("R9 masked irq", 32'(irq), 0);
    rdEn = 1'b1; addr = 8'h0C;
    waitN(5);
    rdEn = 1'b0; addr = 8'h00;
    peek(8'h04, v); check("R7 flag kept", v, 1);
    peek(8'h0C, v); check("R7 count kept", v, valWord(1, 0));
    doWrite(8'h00, EN | IE | 32'd3);
    check("R9 irq unmasked", 32'(irq), 1);
    doAck(v); check("R6 ack returns word", v, valWord(1, 0));
    peek(8'h04, v); check("R6 flag cleared", v, 0);
    peek(8'h0C, v); check("R6 count cleared", v, valWord(0, 0));
    check("R9 irq drops", 32'(irq), 0);
    stopAndClear();
  endtask

  task automatic testCoincide();
    logic [31:0] v;
    doWrite(8'h00, EN);
    waitN(31); peek(8'h0C, v); check("R8 one pending", v, valWord(1, 0));
    doAck(v);
    peek(8'h04, v); check("R8 flag stays", v, 1);
    peek(8'h0C, v); check("R8 count is one", v, valWord(1, 0));
    stopAndClear();
  endtask

  task automatic testDrain();
    logic [31:0] v;
    doWrite(8'h00, EN | 32'd3);
    waitN(20);
    doWrite(8'h00, 32'd3);
    peek(8'h00, v); check("R10 enable cleared", v, 32'd3);
    waitN(19); peek(8'h0C, v); check("R10 still counting", v, valWord(0, 2));
    waitN(30); peek(8'h0C, v); check("R10 final wrap", v, valWord(1, 0));
    peek(8'h04, v); check("R10 final flag", v, 1);
    doAck(v);
    waitN(200);
    peek(8'h0C, v); check("R10 held after stop", v, 0);
    peek(8'h04, v); check("R10 no later flag", v, 0);
  endtask

  task automatic testWrap();
    logic [31:0] v;
    doWrite(8'h00, EN);
    waitN(16 * 4095 + 8);
    peek(8'h0C, v); check("R5 count 4095", v, valWord(4095, 0));
    waitN(16);
    peek(8'h0C, v); check("R5 wraps to 0", v, valWord(0, 0));
    peek(8'h04, v); check("R5 flag set", v, 1);
    stopAndClear();
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    testReset();
    testModeReg();
    testIgnored();
    testTiming();
    testSequence();
    testCoincide();
    testDrain();
    testWrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule